// File: doc/BRIEF.md
# Set/Clear Paired Control Register Bank

This block is a bank of 32-bit control words behind a simple word-addressed read/write bus. Several control words have a companion alias one word above them: writing the main address ORs the data into the word, and writing the alias removes the data's 1 bits from it. Two strap words capture their values from input ports at reset. After reset they accept set and clear writes. A protect word two words above each strap word blocks later set writes to it, but not clear writes.

A few addresses have fixed behaviour. Three PLL extension words always read back with the lock bit (bit 31) set. Two revision words are read-only copies of an input port. A random-number word returns a fresh value on every read and ignores writes. A key word records whether the unlock constant was last written to it, without gating any other write. Every other word in the address space is plain storage. Plain words are held in a memory without reset so that block RAM can be inferred.

Register locations below are given as byte offsets. The bus address `addr` is the byte offset divided by four. A read issued with `rd_en` returns its data on `rdata` with `rdata_vld` high two clock edges later.

Top module: `setclr_reg_bank`

## Requirements
- R1: After reset the words read as follows: 0x40 = 0xF7CFFFDC, 0x50 = 0xFFFFFFFC, 0x80 = 0xEFF43E8B, 0x90 = 0xFFF0FFF0, 0x100 = 0x00000040, 0x200 = 0x1000405F, 0x00 = 0, 0x508 = 0, 0x518 = 0. Offsets 0x04 and 0x14 both read `rev_in`. Offset 0x500 reads `strap_a_in` and offset 0x510 reads `strap_b_in`, each as sampled during reset.
- R2: A write to 0x40, 0x50, 0x80 or 0x90 ORs `wdata` into that word.
- R3: A write to 0x44, 0x54, 0x84 or 0x94 clears, in the word one word below, every bit that is 1 in `wdata`. These alias addresses always read as 0.
- R4: A write to strap word 0x500 (or 0x510) ORs `wdata` into it while its protect word 0x508 (or 0x518) is zero. While the protect word is nonzero, the write is dropped. Protect words are stored and read back as full words.
- R5: A write to 0x504 (or 0x514) clears the `wdata` 1 bits in strap word 0x500 (or 0x510), whether or not that strap word is protected.
- R6: Reads of 0x204, 0x224 and 0x244 return the last written value with bit 31 forced to 1.
- R7: Writes to 0x04, 0x14 and 0x540 have no effect on what those addresses read.
- R8: Each read of 0x540 returns a nonzero word that differs from the word returned by the previous read of 0x540.
- R9: Writing 0x00 stores 1 when `wdata` equals the parameter `UNLOCK_KEY` and stores 0 for any other value. The key value never blocks writes to any other address.
- R10: A write to any address without a special rule above replaces the whole word, and a later read returns it unchanged.
- R11: `rdata_vld` is high for exactly one cycle, two clock edges after the edge that accepts `rd_en`. A read accepted on the same edge as a write to the same address returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Word address (byte offset / 4) |
| wdata | input | 32 | Write data |
| rev_in | input | 32 | Revision value captured at reset |
| strap_a_in | input | 32 | Strap word A captured at reset |
| strap_b_in | input | 32 | Strap word B captured at reset |
| rdata | output | 32 | Read data, registered |
| rdata_vld | output | 1 | Read data valid |

## Verification
A write changes state on the edge that accepts it, so a read issued in the next cycle already sees the new value. Read data arrives two edges after the read is accepted. The bench therefore records, for each read it issues, the expected value and the cycle number of issue in a queue. A monitor samples on the falling edge and checks that every valid pulse falls exactly two cycles after the issue recorded at the head of the queue. Reads of the random word carry no fixed expectation. Their values are collected, then checked for being nonzero and for differing from the previous read.

// File: rtl/setclr_bank_pkg.sv
package setclr_bank_pkg;

  localparam int DW = 32;

  typedef enum logic [3:0] {
    K_PLAIN, K_KEY, K_REV, K_SET, K_CLR, K_STRAP, K_STRAP_CLR,
    K_PROT, K_PLLX, K_RNG, K_HSK, K_HPLL
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] idx;
  } dec_t;

  // word addresses (byte offset / 4)
  localparam int NSET   = 4;
  localparam int NSTRAP = 2;
  localparam int unsigned WA_KEY  = 0;
  localparam int unsigned WA_REV0 = 1;
  localparam int unsigned WA_REV1 = 5;
  localparam int unsigned WA_HSK  = 64;
  localparam int unsigned WA_HPLL = 128;
  localparam int unsigned WA_RNG  = 336;
  localparam int unsigned SET_WA   [NSET]   = '{16, 20, 32, 36};
  localparam int unsigned STRAP_WA [NSTRAP] = '{320, 324};
  localparam int unsigned PLLX_WA  [3]      = '{129, 137, 145};

  localparam logic [NSET*DW-1:0] SET_RST = {
    32'hFFF0_FFF0, 32'hEFF4_3E8B, 32'hFFFF_FFFC, 32'hF7CF_FFDC};
  localparam logic [DW-1:0] HSK_RST  = 32'h0000_0040;
  localparam logic [DW-1:0] HPLL_RST = 32'h1000_405F;

endpackage

// File: rtl/setclr_bank_decode.sv
module setclr_bank_decode
  import setclr_bank_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  always_comb begin
    dec = '{kind: K_PLAIN, idx: 2'd0};
    if (addr == ADDR_W'(WA_KEY)) dec.kind = K_KEY;
    if (addr == ADDR_W'(WA_REV0) || addr == ADDR_W'(WA_REV1)) dec.kind = K_REV;
    if (addr == ADDR_W'(WA_HSK))  dec.kind = K_HSK;
    if (addr == ADDR_W'(WA_HPLL)) dec.kind = K_HPLL;
    if (addr == ADDR_W'(WA_RNG))  dec.kind = K_RNG;
    for (int i = 0; i < 3; i++)
      if (addr == ADDR_W'(PLLX_WA[i])) dec.kind = K_PLLX;
    for (int i = 0; i < NSET; i++) begin
      if (addr == ADDR_W'(SET_WA[i]))     dec = '{kind: K_SET, idx: 2'(i)};
      if (addr == ADDR_W'(SET_WA[i] + 1)) dec = '{kind: K_CLR, idx: 2'(i)};
    end
    for (int i = 0; i < NSTRAP; i++) begin
      if (addr == ADDR_W'(STRAP_WA[i]))     dec = '{kind: K_STRAP, idx: 2'(i)};
      if (addr == ADDR_W'(STRAP_WA[i] + 1)) dec = '{kind: K_STRAP_CLR, idx: 2'(i)};
      if (addr == ADDR_W'(STRAP_WA[i] + 2)) dec = '{kind: K_PROT, idx: 2'(i)};
    end
  end
endmodule

// File: rtl/setclr_ctrl_regs.sv
module setclr_ctrl_regs
  import setclr_bank_pkg::*;
#(
  parameter int N = NSET,
  parameter logic [N*DW-1:0] RST_VEC = SET_RST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  dec_t              dec,
  input  logic [DW-1:0]     wdata,
  output logic [N-1:0][DW-1:0] q
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) q[i] <= RST_VEC[i*DW +: DW];
      else if (we && dec.idx == 2'(i) && dec.kind == K_SET) q[i] <= q[i] | wdata;
      else if (we && dec.idx == 2'(i) && dec.kind == K_CLR) q[i] <= q[i] & ~wdata;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_set_or_R2: assert property (@(posedge clk) disable iff (rst)
      (we && dec.kind == K_SET && dec.idx == 2'(g)) |=> ((q[g] & $past(wdata)) == $past(wdata)));
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (we && dec.kind == K_CLR && dec.idx == 2'(g)) |=> ((q[g] & $past(wdata)) == '0));
  end
endmodule

// File: rtl/setclr_strap_regs.sv
module setclr_strap_regs
  import setclr_bank_pkg::*;
#(
  parameter int N = NSTRAP
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  dec_t                 dec,
  input  logic [DW-1:0]        wdata,
  input  logic [N-1:0][DW-1:0] strap_in,
  output logic [N-1:0][DW-1:0] q,
  output logic [N-1:0][DW-1:0] prot
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        q[i]    <= strap_in[i];
        prot[i] <= '0;
      end else if (we && dec.idx == 2'(i)) begin
        if (dec.kind == K_STRAP && prot[i] == '0) q[i] <= q[i] | wdata;
        if (dec.kind == K_STRAP_CLR)              q[i] <= q[i] & ~wdata;
        if (dec.kind == K_PROT)                   prot[i] <= wdata;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_protect_R4: assert property (@(posedge clk) disable iff (rst)
      (we && dec.kind == K_STRAP && dec.idx == 2'(g) && prot[g] != '0) |=> $stable(q[g]));
    assert_clr_protected_R5: assert property (@(posedge clk) disable iff (rst)
      (we && dec.kind == K_STRAP_CLR && dec.idx == 2'(g)) |=> ((q[g] & $past(wdata)) == '0));
  end
endmodule

// File: rtl/setclr_bank_rng.sv
module setclr_bank_rng
  import setclr_bank_pkg::*;
#(
  parameter logic [DW-1:0] SEED = 32'h6D2B_79F5,
  parameter logic [DW-1:0] POLY = 32'h8020_0003
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [DW-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else if (adv) state <= state[0] ? ((state >> 1) ^ POLY) : (state >> 1);
  end

  assert_nonzero_R8: assert property (@(posedge clk) disable iff (rst) state != '0);
  assert_advance_R8: assert property (@(posedge clk) disable iff (rst)
    adv |=> state != $past(state));
endmodule

// File: rtl/setclr_reg_bank.sv
module setclr_reg_bank
  import setclr_bank_pkg::*;
#(
  parameter int              ADDR_W     = 9,
  parameter logic [DW-1:0]   UNLOCK_KEY = 32'hA5C3_0F96,
  parameter logic [DW-1:0]   RNG_SEED   = 32'h6D2B_79F5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     rev_in,
  input  logic [DW-1:0]     strap_a_in,
  input  logic [DW-1:0]     strap_b_in,
  output logic [DW-1:0]     rdata,
  output logic              rdata_vld
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LOCK_BIT = DW - 1;

  dec_t dec;
  logic [NSET-1:0][DW-1:0]   set_q;
  logic [NSTRAP-1:0][DW-1:0] strap_q, prot_q;
  logic [DW-1:0] rng_q, rev_q, hsk_q, hpll_q, spec_v, spec1, mem_q;
  logic          key_q, rv1;
  kind_e         kind1;
  logic [DW-1:0] mem [DEPTH];

  setclr_bank_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .dec(dec));

  setclr_ctrl_regs #(.N(NSET), .RST_VEC(SET_RST)) u_ctrl (
    .clk(clk), .rst(rst), .we(wr_en), .dec(dec), .wdata(wdata), .q(set_q));

  setclr_strap_regs #(.N(NSTRAP)) u_strap (
    .clk(clk), .rst(rst), .we(wr_en), .dec(dec), .wdata(wdata),
    .strap_in({strap_b_in, strap_a_in}), .q(strap_q), .prot(prot_q));

  setclr_bank_rng #(.SEED(RNG_SEED)) u_rng (
    .clk(clk), .rst(rst), .adv(rd_en && dec.kind == K_RNG), .state(rng_q));

  // small dedicated words with reset values
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= 1'b0;
      rev_q  <= rev_in;
      hsk_q  <= HSK_RST;
      hpll_q <= HPLL_RST;
    end else if (wr_en) begin
      if (dec.kind == K_KEY)  key_q  <= (wdata == UNLOCK_KEY);
      if (dec.kind == K_HSK)  hsk_q  <= wdata;
      if (dec.kind == K_HPLL) hpll_q <= wdata;
    end
  end

  // plain storage: no reset, read-before-write, block RAM style
  always_ff @(posedge clk) begin
    if (wr_en && (dec.kind == K_PLAIN || dec.kind == K_PLLX)) mem[addr] <= wdata;
    if (rd_en) mem_q <= mem[addr];
  end

  always_comb begin
    unique case (dec.kind)
      K_KEY:   spec_v = {{(DW-1){1'b0}}, key_q};
      K_REV:   spec_v = rev_q;
      K_SET:   spec_v = set_q[dec.idx];
      K_STRAP: spec_v = strap_q[dec.idx[0]];
      K_PROT:  spec_v = prot_q[dec.idx[0]];
      K_RNG:   spec_v = rng_q;
      K_HSK:   spec_v = hsk_q;
      K_HPLL:  spec_v = hpll_q;
      default: spec_v = '0;
    endcase
  end

  // read pipeline: stage 1 captures, stage 2 selects
  always_ff @(posedge clk) begin
    if (rst) begin
      rv1       <= 1'b0;
      kind1     <= K_PLAIN;
      spec1     <= '0;
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rv1       <= rd_en;
      if (rd_en) begin
        kind1 <= dec.kind;
        spec1 <= spec_v;
      end
      rdata_vld <= rv1;
      if (rv1) begin
        if (kind1 == K_PLAIN)     rdata <= mem_q;
        else if (kind1 == K_PLLX) rdata <= mem_q | (DW'(1) << LOCK_BIT);
        else                      rdata <= spec1;
      end
    end
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 rdata_vld);
  assert_lock_R6: assert property (@(posedge clk) disable iff (rst)
    (rv1 && kind1 == K_PLLX) |=> rdata[LOCK_BIT]);
  assert_key_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dec.kind == K_KEY) |=> (key_q == ($past(wdata) == UNLOCK_KEY)));
endmodule

// File: tb/setclr_reg_bank_test.sv
module setclr_reg_bank_test;
  localparam int AW = 9;
  localparam logic [31:0] KEY = 32'hA5C3_0F96;
  localparam logic [31:0] REV = 32'h0503_0303;
  localparam logic [31:0] SA  = 32'h0000_1234;
  localparam logic [31:0] SB  = 32'h00AB_CD00;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rdata_vld;

  always #10 clk = ~clk;

  setclr_reg_bank #(.ADDR_W(AW), .UNLOCK_KEY(KEY)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rev_in(REV), .strap_a_in(SA), .strap_b_in(SB),
    .rdata(rdata), .rdata_vld(rdata_vld));

  typedef struct {
    logic [31:0] exp;
    bit          rng;
    string       tag;
    int          issue;
  } item_t;

  item_t sbq[$];
  logic [31:0] rng_seen[$];
  int errors = 0, checks = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    if (!rst && rdata_vld) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected valid: got %h exp none", rdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (cyc != it.issue + 2) begin
          errors++;
          $display("FAIL R11 latency (%s): got %0d exp %0d", it.tag, cyc - it.issue, 2);
        end
        if (it.rng) rng_seen.push_back(rdata);
        else begin
          checks++;
          if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", it.tag, rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(off >> 2); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int off, input logic [31:0] e, input string tag, input bit rng = 0);
    item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(off >> 2);
    it.exp = e; it.rng = rng; it.tag = tag; it.issue = cyc;
    sbq.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rw_same(input int off, input logic [31:0] d, input logic [31:0] old, input string tag);
    item_t it;
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = AW'(off >> 2); wdata = d;
    it.exp = old; it.rng = 0; it.tag = tag; it.issue = cyc;
    sbq.push_back(it);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset values (back-to-back reads)
    rd(32'h040, 32'hF7CF_FFDC, "R1 rst 0x40");
    rd(32'h050, 32'hFFFF_FFFC, "R1 rst 0x50");
    rd(32'h080, 32'hEFF4_3E8B, "R1 rst 0x80");
    rd(32'h090, 32'hFFF0_FFF0, "R1 rst 0x90");
    rd(32'h100, 32'h0000_0040, "R1 rst 0x100");
    rd(32'h200, 32'h1000_405F, "R1 rst 0x200");
    rd(32'h004, REV, "R1 rev 0x04");
    rd(32'h014, REV, "R1 rev 0x14");
    rd(32'h500, SA, "R1 strap A");
    rd(32'h510, SB, "R1 strap B");
    rd(32'h000, 32'h0, "R1 key");
    rd(32'h508, 32'h0, "R1 prot A");
    rd(32'h518, 32'h0, "R1 prot B");
    // R2 set
    wr(32'h040, 32'h0000_0023);
    rd(32'h040, 32'hF7CF_FFFF, "R2 or 0x40");
    wr(32'h090, 32'h0000_000F);
    rd(32'h090, 32'hFFF0_FFFF, "R2 or 0x90");
    // R3 clear aliases
    wr(32'h044, 32'hF000_0000);
    rd(32'h040, 32'h07CF_FFFF, "R3 clr 0x40");
    rd(32'h044, 32'h0, "R3 alias reads 0");
    wr(32'h084, 32'h0000_000B);
    rd(32'h080, 32'hEFF4_3E80, "R3 clr 0x80");
    wr(32'h054, 32'hFFFF_FFFF);
    rd(32'h050, 32'h0, "R3 clr 0x50");
    // R4 strap set and protect
    wr(32'h500, 32'h0001_0000);
    rd(32'h500, 32'h0001_1234, "R4 strap set");
    wr(32'h508, 32'h0000_0001);
    rd(32'h508, 32'h0000_0001, "R4 prot readback");
    wr(32'h500, 32'hFF00_0000);
    rd(32'h500, 32'h0001_1234, "R4 protected write dropped");
    // R5 clear ignores protection
    wr(32'h504, 32'h0000_0034);
    rd(32'h500, 32'h0001_1200, "R5 clear while protected");
    wr(32'h514, 32'h0000_CD00);
    rd(32'h510, 32'h00AB_0000, "R5 clear strap B");
    wr(32'h510, 32'h0000_0001);
    rd(32'h510, 32'h00AB_0001, "R4 strap B set");
    // R6 lock bit
    wr(32'h204, 32'h0000_0055);
    rd(32'h204, 32'h8000_0055, "R6 pll 0x204");
    wr(32'h224, 32'h8000_0001);
    rd(32'h224, 32'h8000_0001, "R6 pll 0x224");
    wr(32'h244, 32'h0);
    rd(32'h244, 32'h8000_0000, "R6 pll 0x244");
    // R7 read-only
    wr(32'h004, 32'hFFFF_FFFF);
    rd(32'h004, REV, "R7 rev 0x04 ignored");
    wr(32'h014, 32'h0);
    rd(32'h014, REV, "R7 rev 0x14 ignored");
    wr(32'h540, 32'h0);
    // R8 random reads (first also shows R7 write had no effect: nonzero)
    rd(32'h540, 32'h0, "R8 rng", 1);
    rd(32'h540, 32'h0, "R8 rng", 1);
    rd(32'h540, 32'h0, "R8 rng", 1);
    drain();
    for (int i = 0; i < rng_seen.size(); i++) begin
      checks++;
      if (rng_seen[i] == 32'h0) begin
        errors++; $display("FAIL R7/R8 rng zero: got %h exp nonzero", rng_seen[i]);
      end
      if (i > 0) begin
        checks++;
        if (rng_seen[i] == rng_seen[i-1]) begin
          errors++; $display("FAIL R8 rng repeat: got %h exp != %h", rng_seen[i], rng_seen[i-1]);
        end
      end
    end
    checks++;
    if (rng_seen.size() != 3) begin
      errors++; $display("FAIL R8 rng count: got %0d exp %0d", rng_seen.size(), 3);
    end
    // R9 key
    wr(32'h000, KEY);
    rd(32'h000, 32'h1, "R9 unlock");
    wr(32'h000, KEY ^ 32'h1);
    rd(32'h000, 32'h0, "R9 wrong key locks");
    wr(32'h100, 32'h1234_5678);
    rd(32'h100, 32'h1234_5678, "R9 locked write still applies");
    wr(32'h040, 32'h3000_0000);
    rd(32'h040, 32'h37CF_FFFF, "R9 locked set applies");
    // R10 plain words
    wr(32'h300, 32'hDEAD_BEEF);
    rd(32'h300, 32'hDEAD_BEEF, "R10 plain write");
    wr(32'h300, 32'h0000_0001);
    rd(32'h300, 32'h0000_0001, "R10 full replace");
    wr(32'h200, 32'h0000_0000);
    rd(32'h200, 32'h0000_0000, "R10 hpll replace");
    // R11 read-before-write
    rw_same(32'h300, 32'hCAFE_F00D, 32'h0000_0001, "R11 same-cycle read old");
    rd(32'h300, 32'hCAFE_F00D, "R11 next read new");
    drain();
    checks++;
    if (sbq.size() != 0) begin
      errors++; $display("FAIL R11 missing results: got %0d exp %0d", sbq.size(), 0);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule